// File: doc/BRIEF.md
# Branch Direction Predictor with Static Fallback

This block guesses whether a conditional branch will be taken. It holds a direct-mapped table of 2-bit saturating counters, and each entry has its own flag that marks it as trained. The fetch side presents a branch address and the sign of the branch displacement. The predictor answers in the same cycle. An entry that has never been trained falls back to a fixed rule: a backward branch (negative displacement) is guessed taken and a forward branch is guessed not taken.

The commit side trains the table. For each retired conditional branch it presents the branch address and the real outcome. A branch counts as taken when the next retired instruction does not sit directly after the branch, that is, its address differs from the branch address plus the branch's size. The caller derives this outcome before it drives the update port. A training write marks the entry trained and moves its counter one step toward the outcome, stopping at the ends of the range.

Top module: `branch_dir_predictor`

## Requirements
- R1: After synchronous reset every entry is untrained with a counter of 0, so every lookup follows the static rule of R2.
- R2: For an untrained entry, `pred_taken` equals bit XLEN-1 (the sign bit) of `look_offset`: 1 for a negative displacement and 0 otherwise.
- R3: For a trained entry, `pred_taken` is 1 exactly when the counter is 2 or 3, whatever the displacement sign.
- R4: A training write with `train_taken`=1 marks the entry trained and raises its counter by one, stopping at 3. The new value is seen by lookups from the clock cycle after the write.
- R5: A training write with `train_taken`=0 marks the entry trained and lowers its counter by one, stopping at 0.
- R6: The entry index is (address >> 1) modulo ENTRIES. Address bit 0 therefore has no effect, addresses 2*ENTRIES apart share an entry, and neighbouring indices do not disturb each other.
- R7: When a lookup and a training write address the same entry in the same cycle, the lookup returns the prediction from the contents before the write.
- R8: While `train_en` is 0, `train_pc` and `train_taken` leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| look_pc | input | XLEN | Address of the branch being predicted |
| look_offset | input | XLEN | Signed displacement of that branch; only its sign bit is used |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| train_en | input | 1 | Training write strobe from commit |
| train_pc | input | XLEN | Address of the retired branch |
| train_taken | input | 1 | Real outcome of the retired branch |

## Verification
A lookup has no register in its path, so `pred_taken` is due in the same cycle as the address and displacement. A training write lands on the next rising edge, so its effect is first visible to the lookup in the cycle after the strobe. The bench drives each step on the falling edge, compares `pred_taken` shortly after that, and lets the rising edge commit the step's training write. Each comparison therefore reflects every earlier write and none of the current one, which is exactly the same-cycle case of R7. Counter values are never read directly. They are inferred from sequences of writes whose predictions differ at the threshold and at each saturation end.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    localparam int CTR_W      = 2;
    localparam int CTR_TOP    = (1 << CTR_W) - 1;
    localparam int CTR_THRESH = 1 << (CTR_W - 1);

    typedef struct packed {
        logic             trained;
        logic [CTR_W-1:0] ctr;
    } bdp_entry_t;

    // next state of an entry after one retired branch
    function automatic bdp_entry_t bdp_train(bdp_entry_t cur, logic taken);
        bdp_entry_t nxt;
        nxt.trained = 1'b1;
        nxt.ctr     = cur.ctr;
        if (taken) begin
            if (cur.ctr != CTR_W'(CTR_TOP)) nxt.ctr = cur.ctr + CTR_W'(1);
        end else begin
            if (cur.ctr != '0) nxt.ctr = cur.ctr - CTR_W'(1);
        end
        return nxt;
    endfunction

    // direction guess: counter when trained, sign rule otherwise
    function automatic logic bdp_guess(bdp_entry_t ent, logic backward);
        if (ent.trained) return (ent.ctr >= CTR_W'(CTR_THRESH));
        return backward;
    endfunction

endpackage

// File: rtl/bdp_index.sv
module bdp_index #(
    parameter int XLEN    = 32,
    parameter int ENTRIES = 128,
    parameter int IDXW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [XLEN-1:0] pc,
    output logic [IDXW-1:0] idx
);
    localparam bit POW2 = (ENTRIES & (ENTRIES - 1)) == 0;

    logic [XLEN-1:0] halfword;
    assign halfword = pc >> 1;

    generate
        if (ENTRIES == 1) begin : g_single
            assign idx = '0;
        end else if (POW2) begin : g_slice
            assign idx = halfword[IDXW-1:0];
        end else begin : g_mod
            logic [XLEN-1:0] rem;
            assign rem = halfword % XLEN'(ENTRIES);
            assign idx = rem[IDXW-1:0];
        end
    endgenerate
endmodule

// File: rtl/bdp_table.sv
module bdp_table
    import bdp_pkg::*;
#(
    parameter int ENTRIES = 128,
    parameter int IDXW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [IDXW-1:0]            rd_idx,
    output bdp_entry_t                 rd_ent,
    input  logic                       wr_en,
    input  logic [IDXW-1:0]            wr_idx,
    input  logic                       wr_taken,
    output bdp_entry_t [ENTRIES-1:0]   ent_q
);
    // read before write: the read port sees stored state only
    assign rd_ent = ent_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
        end else if (wr_en) begin
            ent_q[wr_idx] <= bdp_train(ent_q[wr_idx], wr_taken);
        end
    end
endmodule

// File: rtl/bdp_decide.sv
module bdp_decide
    import bdp_pkg::*;
(
    input  bdp_entry_t ent,
    input  logic       backward,
    output logic       taken
);
    always_comb taken = bdp_guess(ent, backward);
endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor
    import bdp_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int ENTRIES = 128
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] look_pc,
    input  logic [XLEN-1:0] look_offset,
    output logic            pred_taken,
    input  logic            train_en,
    input  logic [XLEN-1:0] train_pc,
    input  logic            train_taken
);
    localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [IDXW-1:0]          look_idx;
    logic [IDXW-1:0]          train_idx;
    bdp_entry_t               look_ent;
    bdp_entry_t [ENTRIES-1:0] ent_q;

    bdp_index #(.XLEN(XLEN), .ENTRIES(ENTRIES), .IDXW(IDXW)) u_idx_look (
        .pc (look_pc),
        .idx(look_idx)
    );

    bdp_index #(.XLEN(XLEN), .ENTRIES(ENTRIES), .IDXW(IDXW)) u_idx_train (
        .pc (train_pc),
        .idx(train_idx)
    );

    bdp_table #(.ENTRIES(ENTRIES), .IDXW(IDXW)) u_tab (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (look_idx),
        .rd_ent  (look_ent),
        .wr_en   (train_en),
        .wr_idx  (train_idx),
        .wr_taken(train_taken),
        .ent_q   (ent_q)
    );

    bdp_decide u_dec (
        .ent     (look_ent),
        .backward(look_offset[XLEN-1]),
        .taken   (pred_taken)
    );
endmodule

// File: rtl/bdp_checker.sv
module bdp_checker
    import bdp_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int ENTRIES = 128,
    parameter int IDXW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic [XLEN-1:0]          look_offset,
    input logic                     pred_taken,
    input bdp_entry_t               look_ent,
    input logic                     train_en,
    input logic                     train_taken,
    input logic [IDXW-1:0]          train_idx,
    input bdp_entry_t [ENTRIES-1:0] ent_q
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> (ent_q == '0));

    // R2
    static_rule_chk: assert property (@(posedge clk) disable iff (rst)
        !look_ent.trained |-> (pred_taken == look_offset[XLEN-1]));

    // R3
    counter_rule_chk: assert property (@(posedge clk) disable iff (rst)
        look_ent.trained |-> (pred_taken == look_ent.ctr[CTR_W-1]));

    // R4
    marks_trained_chk: assert property (@(posedge clk) disable iff (rst)
        train_en |=> ent_q[$past(train_idx)].trained);

    // R4
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (train_en && train_taken && ent_q[train_idx].ctr != CTR_W'(CTR_TOP))
        |=> (ent_q[$past(train_idx)].ctr == $past(ent_q[train_idx].ctr) + CTR_W'(1)));

    // R4
    top_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (train_en && train_taken && ent_q[train_idx].ctr == CTR_W'(CTR_TOP))
        |=> (ent_q[$past(train_idx)].ctr == CTR_W'(CTR_TOP)));

    // R5
    floor_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (train_en && !train_taken && ent_q[train_idx].ctr == '0)
        |=> (ent_q[$past(train_idx)].ctr == '0));

    // R8
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !train_en |=> $stable(ent_q));
endmodule

bind branch_dir_predictor bdp_checker #(.XLEN(XLEN), .ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .look_offset(look_offset),
    .pred_taken (pred_taken),
    .look_ent   (look_ent),
    .train_en   (train_en),
    .train_taken(train_taken),
    .train_idx  (train_idx),
    .ent_q      (ent_q)
);

// File: tb/branch_dir_predictor_tb.sv
module branch_dir_predictor_tb;

    localparam int XLEN = 32;
    localparam logic [31:0] PA  = 32'h0000_0040; // index 32
    localparam logic [31:0] PB  = 32'h0000_0042; // index 33
    localparam logic [31:0] PAO = 32'h0000_0041; // index 32, bit 0 set
    localparam logic [31:0] PAL = 32'h0000_0140; // index 32 by aliasing

    typedef struct packed {
        logic        ten;
        logic [31:0] tpc;
        logic        tt;
        logic [31:0] lpc;
        logic        back;
        logic        exp;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 22;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b0, PA,  1'b1, PA,  1'b0, 1'b0, 4'd2}, // 0  R2 forward untrained
        '{1'b0, PA,  1'b1, PA,  1'b1, 1'b1, 4'd2}, // 1  R2 backward untrained
        '{1'b1, PA,  1'b0, PA,  1'b1, 1'b1, 4'd7}, // 2  R7 sees untrained, ctr->0
        '{1'b0, PA,  1'b1, PA,  1'b1, 1'b0, 4'd3}, // 3  R3 trained ctr0 beats sign
        '{1'b1, PA,  1'b1, PA,  1'b1, 1'b0, 4'd4}, // 4  R4 ctr0->1
        '{1'b1, PA,  1'b1, PA,  1'b0, 1'b0, 4'd4}, // 5  R4 sees 1, ->2
        '{1'b0, PA,  1'b1, PA,  1'b0, 1'b1, 4'd3}, // 6  R3 ctr2 taken
        '{1'b1, PA,  1'b1, PA,  1'b0, 1'b1, 4'd4}, // 7  ->3
        '{1'b1, PA,  1'b1, PA,  1'b0, 1'b1, 4'd4}, // 8  R4 stays 3
        '{1'b1, PA,  1'b0, PA,  1'b0, 1'b1, 4'd5}, // 9  3->2
        '{1'b0, PA,  1'b0, PA,  1'b0, 1'b1, 4'd4}, // 10 ctr2
        '{1'b1, PA,  1'b0, PA,  1'b0, 1'b1, 4'd5}, // 11 2->1
        '{1'b0, PA,  1'b1, PA,  1'b0, 1'b0, 4'd4}, // 12 ctr1 proves top saturation
        '{1'b1, PA,  1'b0, PA,  1'b0, 1'b0, 4'd8}, // 13 R8 step 12 ignored, 1->0
        '{1'b1, PA,  1'b0, PA,  1'b0, 1'b0, 4'd5}, // 14 R5 stays 0
        '{1'b1, PA,  1'b1, PA,  1'b1, 1'b0, 4'd5}, // 15 R5 no wrap below 0, ->1
        '{1'b0, PA,  1'b0, PA,  1'b1, 1'b0, 4'd3}, // 16 ctr1 not taken
        '{1'b0, PA,  1'b0, PB,  1'b1, 1'b1, 4'd6}, // 17 R6 neighbour untrained
        '{1'b1, PAO, 1'b1, PAO, 1'b0, 1'b0, 4'd6}, // 18 R6 bit0 ignored, ->2
        '{1'b0, PA,  1'b0, PA,  1'b0, 1'b1, 4'd6}, // 19 R6 same entry trained
        '{1'b0, PA,  1'b0, PAL, 1'b0, 1'b1, 4'd6}, // 20 R6 alias 2*ENTRIES apart
        '{1'b0, PA,  1'b0, PB,  1'b0, 1'b0, 4'd6}  // 21 R6 neighbour untouched
    };

    logic            clk = 1'b0;
    logic            rst;
    logic [XLEN-1:0] look_pc;
    logic [XLEN-1:0] look_offset;
    logic            pred_taken;
    logic            train_en;
    logic [XLEN-1:0] train_pc;
    logic            train_taken;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    branch_dir_predictor #(.XLEN(XLEN), .ENTRIES(128)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .look_pc    (look_pc),
        .look_offset(look_offset),
        .pred_taken (pred_taken),
        .train_en   (train_en),
        .train_pc   (train_pc),
        .train_taken(train_taken)
    );

    task automatic check(input logic got, input logic exp, input int req, input int tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d (step %0d): pred_taken=%0b expected=%0b", req, tag, got, exp);
        end
    endtask

    // drive on the falling edge, compare before the next rising edge
    task automatic step(input logic ten, input logic [31:0] tpc, input logic tt,
                        input logic [31:0] lpc, input logic back,
                        input logic exp, input int req, input int tag);
        @(negedge clk);
        train_en    = ten;
        train_pc    = tpc;
        train_taken = tt;
        look_pc     = lpc;
        look_offset = back ? 32'hFFFF_FFF0 : 32'h0000_0010;
        #2;
        check(pred_taken, exp, req, tag);
    endtask

    initial begin
        rst = 1'b1;
        train_en = 1'b0; train_pc = '0; train_taken = 1'b0;
        look_pc = '0; look_offset = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state follows the static rule
        step(1'b0, PA, 1'b0, PA, 1'b1, 1'b1, 1, 100);
        step(1'b0, PA, 1'b0, PB, 1'b0, 1'b0, 1, 101);

        for (int i = 0; i < NSTEP; i++) begin
            step(STEPS[i].ten, STEPS[i].tpc, STEPS[i].tt, STEPS[i].lpc,
                 STEPS[i].back, STEPS[i].exp, int'(STEPS[i].req), i);
        end

        // R4: train PB taken twice, then R1: reset returns it to untrained
        step(1'b1, PB, 1'b1, PB, 1'b0, 1'b0, 4, 200);
        step(1'b1, PB, 1'b1, PB, 1'b0, 1'b0, 4, 201);
        step(1'b0, PB, 1'b0, PB, 1'b0, 1'b1, 4, 202);
        @(negedge clk);
        rst = 1'b1;
        train_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, PB, 1'b0, PB, 1'b0, 1'b0, 1, 203);
        step(1'b0, PB, 1'b0, PA, 1'b1, 1'b1, 1, 204);

        // R8: disabled strobe on a cleared entry stays untrained
        step(1'b0, PA, 1'b1, PA, 1'b0, 1'b0, 8, 205);
        step(1'b0, PA, 1'b0, PA, 1'b1, 1'b1, 8, 206);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule